// File: doc/BRIEF.md
# Streaming Binary Merge Tree

This block merges `L` sorted runs, one per leaf, into a single ascending stream. The stream leaves the root as tuples of up to `P` records. Each leaf takes one record per cycle under valid/ready and flags the final record of its run. The tree is built from two-input merge nodes arranged in `log2(L)` levels.

A node at depth `d` produces `P >> d` records per cycle, and never fewer than one. A node keeps a small buffer for each input. It releases the smallest pending records only once each input either holds a full tuple or has finished. An input that has finished behaves as if it held a key above every real key, so the other input drains.

Where a parent is twice as wide as its children, a packer joins two consecutive child tuples into one parent tuple. Where the widths are equal, the child tuple is wired straight through. Once the final tuple has left a node, the node is ready for a new set of runs, so batches can follow one another without a reset. The configuration must satisfy `L >= 2*P`.

Top module: `mtree_top`

## Requirements
- R1: Across the whole output stream, keys leave in non-decreasing unsigned order, including from one tuple to the next.
- R2: Every record accepted at the leaves appears exactly once at the output; no record is lost and none is duplicated.
- R3: Slot i of an output tuple holds its key in bits [i*KW +: KW] and is marked present by bit i of the slot mask. The present slots always form a prefix that starts at slot 0.
- R4: The end-of-batch flag is raised on exactly one tuple, the one that carries the last remaining record. Nothing more is emitted until new records arrive.
- R5: While the output is valid and not accepted, the valid signal, the keys, the mask and the end flag all hold their values.
- R6: In the cycle after a leaf's end-of-run record is accepted, that leaf's ready signal is low.
- R7: After reset the output is not valid and every leaf is ready.
- R8: A new batch merges correctly right after the previous one, without a reset.
- R9: Duplicate keys and the all-ones key are merged like any other value. An all-ones key is never mistaken for an exhausted input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| leaf_valid_i | input | L | Leaf record valid, one bit per leaf |
| leaf_key_i | input | L*KW | Leaf keys, leaf i at [i*KW +: KW] |
| leaf_last_i | input | L | Leaf record is the last of its run |
| leaf_ready_o | output | L | Leaf may deliver a record |
| out_valid_o | output | 1 | Output tuple valid |
| out_key_o | output | P*KW | Output keys, slot i at [i*KW +: KW] |
| out_mask_o | output | P | Slot-present mask |
| out_last_o | output | 1 | Tuple ends the batch |
| out_ready_i | input | 1 | Consumer accepts the tuple |

## Verification
The bench targets runs of a single record, one long run beside fifteen single-record runs, all-equal keys, and keys packed against the all-ones value. A node that released records too early would emit keys out of order. If an all-ones key were treated as an exhausted input, records would go missing or the stream would end early. A packer that handled a partial final tuple badly would leave holes in the mask or drop the end flag. Random stalls on both edges catch outputs that change while stalled, and a leaf that stays ready after its last record. Back-to-back batches catch state that is not cleared after the end flag.

// File: rtl/mtree_pkg.sv
package mtree_pkg;
  // records per cycle of a node at depth d, clamped to one
  function automatic int lvl_width(input int p, input int d);
    return ((p >> d) > 0) ? (p >> d) : 1;
  endfunction
endpackage

// File: rtl/mtree_pack.sv
module mtree_pack #(
  parameter int H  = 1,
  parameter int KW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  input  logic [H*KW-1:0] in_keys_i,
  input  logic [H-1:0]    in_mask_i,
  input  logic            in_last_i,
  output logic            in_ready_o,
  output logic            out_valid_o,
  output logic [2*H*KW-1:0] out_keys_o,
  output logic [2*H-1:0]  out_mask_o,
  output logic            out_last_o,
  input  logic            out_ready_i
);
  logic [H*KW-1:0] hold_k;
  logic [H-1:0]    hold_m;
  logic            have;
  logic            in_fire;

  assign in_ready_o = !out_valid_o || out_ready_i;
  assign in_fire    = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_k <= '0; hold_m <= '0; have <= 1'b0;
      out_valid_o <= 1'b0; out_keys_o <= '0; out_mask_o <= '0; out_last_o <= 1'b0;
    end else begin
      if (out_valid_o && out_ready_i) out_valid_o <= 1'b0;
      if (in_fire) begin
        if (have) begin
          out_valid_o <= 1'b1;
          out_keys_o  <= {in_keys_i, hold_k};
          out_mask_o  <= {in_mask_i, hold_m};
          out_last_o  <= in_last_i;
          have        <= 1'b0;
        end else if (in_last_i) begin
          // short final tuple: upper half left empty
          out_valid_o <= 1'b1;
          out_keys_o  <= {{(H*KW){1'b0}}, in_keys_i};
          out_mask_o  <= {{H{1'b0}}, in_mask_i};
          out_last_o  <= 1'b1;
        end else begin
          hold_k <= in_keys_i;
          hold_m <= in_mask_i;
          have   <= 1'b1;
        end
      end
    end
  end

  p_pack_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_keys_o) && $stable(out_mask_o)
                                    && $stable(out_last_o));
endmodule

// File: rtl/mtree_merge.sv
module mtree_merge #(
  parameter int W  = 1,
  parameter int KW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            a_valid_i,
  input  logic [W*KW-1:0] a_keys_i,
  input  logic [W-1:0]    a_mask_i,
  input  logic            a_last_i,
  output logic            a_ready_o,
  input  logic            b_valid_i,
  input  logic [W*KW-1:0] b_keys_i,
  input  logic [W-1:0]    b_mask_i,
  input  logic            b_last_i,
  output logic            b_ready_o,
  output logic            o_valid_o,
  output logic [W*KW-1:0] o_keys_o,
  output logic [W-1:0]    o_mask_o,
  output logic            o_last_o,
  input  logic            o_ready_i
);
  localparam int B  = 2 * W;
  localparam int CW = $clog2(B + 1);

  logic [KW-1:0]   buf_q [2][B];
  logic [KW-1:0]   buf_d [2][B];
  logic [CW-1:0]   cnt_q [2];
  logic [CW-1:0]   cnt_d [2];
  logic [1:0]      done_q;
  logic [W*KW-1:0] in_k [2];
  logic [W-1:0]    in_m [2];
  logic [1:0]      in_v, in_l, in_rdy, acc;
  logic [W*KW-1:0] mk;
  logic [W-1:0]    mm;
  int              take [2];
  logic            fire, emit_last;

  assign in_k = '{a_keys_i, b_keys_i};
  assign in_m = '{a_mask_i, b_mask_i};
  assign in_v = {b_valid_i, a_valid_i};
  assign in_l = {b_last_i, a_last_i};
  assign a_ready_o = in_rdy[0];
  assign b_ready_o = in_rdy[1];

  always_comb begin
    for (int s = 0; s < 2; s++) begin
      in_rdy[s] = !done_q[s] && (int'(cnt_q[s]) <= W);
      acc[s]    = in_v[s] && in_rdy[s];
    end
  end

  // pick the W smallest buffered records; a finished side acts as +inf
  always_comb begin
    int ia, ib;
    ia = 0; ib = 0; mk = '0; mm = '0;
    for (int j = 0; j < W; j++) begin
      if (ia < int'(cnt_q[0]) && (ib >= int'(cnt_q[1]) || buf_q[0][ia] <= buf_q[1][ib])) begin
        mk[j*KW +: KW] = buf_q[0][ia]; mm[j] = 1'b1; ia++;
      end else if (ib < int'(cnt_q[1])) begin
        mk[j*KW +: KW] = buf_q[1][ib]; mm[j] = 1'b1; ib++;
      end
    end
    fire = (int'(cnt_q[0]) >= W || done_q[0]) && (int'(cnt_q[1]) >= W || done_q[1])
           && (!o_valid_o || o_ready_i);
    emit_last = &done_q && (int'(cnt_q[0]) + int'(cnt_q[1]) == ia + ib);
    take[0] = fire ? ia : 0;
    take[1] = fire ? ib : 0;
  end

  always_comb begin
    for (int s = 0; s < 2; s++) begin
      int base;
      base = int'(cnt_q[s]) - take[s];
      for (int i = 0; i < B; i++)
        buf_d[s][i] = (i + take[s] < B) ? buf_q[s][i + take[s]] : '0;
      if (acc[s]) begin
        for (int i = 0; i < W; i++)
          if (in_m[s][i]) buf_d[s][base + i] = in_k[s][i*KW +: KW];
      end
      cnt_d[s] = CW'(base + (acc[s] ? $countones(in_m[s]) : 0));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < 2; s++) begin
        for (int i = 0; i < B; i++) buf_q[s][i] <= '0;
        cnt_q[s] <= '0;
      end
      done_q <= '0;
      o_valid_o <= 1'b0; o_keys_o <= '0; o_mask_o <= '0; o_last_o <= 1'b0;
    end else begin
      buf_q <= buf_d;
      cnt_q <= cnt_d;
      for (int s = 0; s < 2; s++)
        if (acc[s] && in_l[s]) done_q[s] <= 1'b1;
      if (fire && emit_last) done_q <= '0;
      if (fire) begin
        o_valid_o <= 1'b1; o_keys_o <= mk; o_mask_o <= mm; o_last_o <= emit_last;
      end else if (o_ready_i) begin
        o_valid_o <= 1'b0;
      end
    end
  end

  function automatic logic slots_ordered(input logic [W*KW-1:0] k, input logic [W-1:0] m);
    logic ok;
    ok = 1'b1;
    for (int j = 1; j < W; j++)
      if (m[j] && k[j*KW +: KW] < k[(j-1)*KW +: KW]) ok = 1'b0;
    return ok;
  endfunction

  p_no_overflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q[0]) <= B && int'(cnt_q[1]) <= B);
  p_mask_prefix_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    o_valid_o |-> ((o_mask_o & (o_mask_o + 1'b1)) == '0));
  p_slot_order_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    o_valid_o |-> slots_ordered(o_keys_o, o_mask_o));
  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    o_valid_o && !o_ready_i |=> o_valid_o && $stable(o_keys_o) && $stable(o_mask_o)
                               && $stable(o_last_o));
  p_ready_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_valid_i && a_ready_o && a_last_i |=> !a_ready_o);
endmodule

// File: rtl/mtree_top.sv
module mtree_top
  import mtree_pkg::*;
#(
  parameter int P  = 4,
  parameter int L  = 16,
  parameter int KW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [L-1:0]    leaf_valid_i,
  input  logic [L*KW-1:0] leaf_key_i,
  input  logic [L-1:0]    leaf_last_i,
  output logic [L-1:0]    leaf_ready_o,
  output logic            out_valid_o,
  output logic [P*KW-1:0] out_key_o,
  output logic [P-1:0]    out_mask_o,
  output logic            out_last_o,
  input  logic            out_ready_i
);
  localparam int N = 2 * L;

  if (L < 2 * P) begin : g_bad_cfg
    $error("mtree_top needs L >= 2*P");
  end

  // node / leaf outputs, heap order: root 1, leaves L..2L-1
  logic            tv [1:N-1];
  logic [P*KW-1:0] tk [1:N-1];
  logic [P-1:0]    tm [1:N-1];
  logic            tl [1:N-1];
  logic            tr [1:N-1];
  // packer outputs feeding the parent node
  logic            cv [2:N-1];
  logic [P*KW-1:0] ck [2:N-1];
  logic [P-1:0]    cm [2:N-1];
  logic            cl [2:N-1];
  logic            cr [2:N-1];

  for (genvar i = 0; i < L; i++) begin : g_leaf
    assign tv[L+i] = leaf_valid_i[i];
    assign tk[L+i] = (P*KW)'(leaf_key_i[i*KW +: KW]);
    assign tm[L+i] = P'(1);
    assign tl[L+i] = leaf_last_i[i];
    assign leaf_ready_o[i] = tr[L+i];
  end

  for (genvar n = 1; n < L; n++) begin : g_node
    localparam int D   = $clog2(n + 1) - 1;
    localparam int NW  = lvl_width(P, D);
    localparam int CWD = lvl_width(P, D + 1);

    for (genvar s = 0; s < 2; s++) begin : g_side
      localparam int C = 2 * n + s;
      if (NW == 2 * CWD) begin : g_pack
        mtree_pack #(.H(CWD), .KW(KW)) u_pack (
          .clk_i, .rst_ni,
          .in_valid_i (tv[C]), .in_keys_i (tk[C][CWD*KW-1:0]), .in_mask_i (tm[C][CWD-1:0]),
          .in_last_i  (tl[C]), .in_ready_o (tr[C]),
          .out_valid_o(cv[C]), .out_keys_o(ck[C][NW*KW-1:0]), .out_mask_o(cm[C][NW-1:0]),
          .out_last_o (cl[C]), .out_ready_i(cr[C])
        );
      end else begin : g_pass
        assign cv[C] = tv[C];
        assign ck[C][NW*KW-1:0] = tk[C][NW*KW-1:0];
        assign cm[C][NW-1:0] = tm[C][NW-1:0];
        assign cl[C] = tl[C];
        assign tr[C] = cr[C];
      end
      if (NW < P) begin : g_pad
        assign ck[C][P*KW-1:NW*KW] = '0;
        assign cm[C][P-1:NW] = '0;
      end
    end

    mtree_merge #(.W(NW), .KW(KW)) u_merge (
      .clk_i, .rst_ni,
      .a_valid_i(cv[2*n]),   .a_keys_i(ck[2*n][NW*KW-1:0]),   .a_mask_i(cm[2*n][NW-1:0]),
      .a_last_i (cl[2*n]),   .a_ready_o(cr[2*n]),
      .b_valid_i(cv[2*n+1]), .b_keys_i(ck[2*n+1][NW*KW-1:0]), .b_mask_i(cm[2*n+1][NW-1:0]),
      .b_last_i (cl[2*n+1]), .b_ready_o(cr[2*n+1]),
      .o_valid_o(tv[n]), .o_keys_o(tk[n][NW*KW-1:0]), .o_mask_o(tm[n][NW-1:0]),
      .o_last_o (tl[n]), .o_ready_i(tr[n])
    );
    if (NW < P) begin : g_pad
      assign tk[n][P*KW-1:NW*KW] = '0;
      assign tm[n][P-1:NW] = '0;
    end
  end

  assign out_valid_o = tv[1];
  assign out_key_o   = tk[1];
  assign out_mask_o  = tm[1];
  assign out_last_o  = tl[1];
  assign tr[1]       = out_ready_i;

  // stream-order monitor across tuples
  logic [KW-1:0] top_key, prev_key;
  logic          have_prev;
  always_comb begin
    top_key = out_key_o[KW-1:0];
    for (int j = 1; j < P; j++)
      if (out_mask_o[j]) top_key = out_key_o[j*KW +: KW];
  end
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_key <= '0; have_prev <= 1'b0;
    end else if (out_valid_o && out_ready_i) begin
      prev_key  <= top_key;
      have_prev <= !out_last_o;
    end
  end

  p_stream_sorted_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && have_prev |-> out_key_o[KW-1:0] >= prev_key);
  p_out_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_key_o) && $stable(out_last_o));
endmodule

// File: tb/mtree_top_test.sv
`timescale 1ns/1ps
module mtree_top_test;
  localparam int P = 4, L = 16, KW = 16, MAXR = 32, TOT = L * MAXR;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [L-1:0]    leaf_valid = '0, leaf_last = '0, leaf_ready;
  logic [L*KW-1:0] leaf_key = '0;
  logic            out_valid, out_last, out_ready = 1'b0;
  logic [P*KW-1:0] out_key;
  logic [P-1:0]    out_mask;

  mtree_top #(.P(P), .L(L), .KW(KW)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .leaf_valid_i(leaf_valid), .leaf_key_i(leaf_key), .leaf_last_i(leaf_last),
    .leaf_ready_o(leaf_ready),
    .out_valid_o(out_valid), .out_key_o(out_key), .out_mask_o(out_mask),
    .out_last_o(out_last), .out_ready_i(out_ready)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  int run_len [L];
  int run_key [L][MAXR];
  int exp_k [TOT];
  int got_k [TOT];
  int exp_n, got_n;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic gen(input int mode);
    exp_n = 0;
    for (int i = 0; i < L; i++) begin
      int k;
      run_len[i] = (mode == 1) ? 1 : (mode == 4) ? ((i == 5) ? MAXR : 1) : 1 + int'($urandom % 20);
      k = (mode == 3) ? 65520 + int'($urandom % 8) : int'($urandom % 200);
      for (int r = 0; r < run_len[i]; r++) begin
        if (mode == 2) k = 7;
        if (k > 65535) k = 65535;
        run_key[i][r] = k;
        exp_k[exp_n] = k;
        exp_n++;
        k += int'($urandom % 4);
      end
    end
    for (int a = 1; a < exp_n; a++) begin
      int v, b;
      v = exp_k[a]; b = a - 1;
      while (b >= 0 && exp_k[b] > v) begin exp_k[b+1] = exp_k[b]; b--; end
      exp_k[b+1] = v;
    end
  endtask

  task automatic run_batch(input int mode, input int in_st, input int out_st);
    int idx [L];
    bit fired [L];
    bit lastf [L];
    bit done, prev_stall, snap_l, sorted_bad, order_bad;
    logic [P*KW-1:0] snap_k;
    logic [P-1:0] snap_m;
    int cycles, lasts, prevmax, last_at, mism;
    gen(mode);
    foreach (idx[i]) begin idx[i] = 0; fired[i] = 0; lastf[i] = 0; end
    done = 0; prev_stall = 0; sorted_bad = 0; order_bad = 0; snap_l = 0;
    snap_k = '0; snap_m = '0;
    cycles = 0; lasts = 0; prevmax = -1; last_at = -1; got_n = 0;
    while (!done && cycles < 20000) begin
      @(negedge clk);
      cycles++;
      if (prev_stall)
        chk(out_valid && out_key == snap_k && out_mask == snap_m && out_last == snap_l,
            "R5 stall hold", int'(out_mask), int'(snap_m));
      out_ready = (int'($urandom % 100) >= out_st);
      if (out_valid && out_ready) begin
        for (int s = 0; s < P; s++) begin
          if (out_mask[s]) begin
            int key;
            key = int'(out_key[s*KW +: KW]);
            if (s > 0 && !out_mask[s-1]) order_bad = 1;
            if (key < prevmax) sorted_bad = 1;
            prevmax = key;
            if (got_n < TOT) got_k[got_n] = key;
            got_n++;
          end
        end
        if (out_last) begin lasts++; last_at = got_n; done = 1; end
      end
      prev_stall = out_valid && !out_ready;
      snap_k = out_key; snap_m = out_mask; snap_l = out_last;
      for (int i = 0; i < L; i++) begin
        if (fired[i]) begin
          if (idx[i] == run_len[i] - 1) lastf[i] = 1;
          idx[i]++;
        end
        if (lastf[i]) chk(!leaf_ready[i], "R6 leaf ready after end of run", int'(leaf_ready[i]), 0);
        lastf[i] = 0;
        if (idx[i] < run_len[i] && int'($urandom % 100) >= in_st) begin
          leaf_valid[i] = 1'b1;
          leaf_key[i*KW +: KW] = KW'(run_key[i][idx[i]]);
          leaf_last[i] = (idx[i] == run_len[i] - 1);
        end else begin
          leaf_valid[i] = 1'b0;
          leaf_last[i] = 1'b0;
        end
        fired[i] = leaf_valid[i] && leaf_ready[i];
      end
    end
    if (!done) chk(0, "watchdog", cycles, 20000);
    chk(!sorted_bad, "R1 stream order", int'(sorted_bad), 0);
    chk(!order_bad, "R3 mask prefix", int'(order_bad), 0);
    chk(got_n == exp_n, "R2 record count", got_n, exp_n);
    mism = 0;
    for (int i = 0; i < exp_n && i < got_n; i++) if (got_k[i] != exp_k[i]) mism++;
    chk(mism == 0, (mode == 3 || mode == 2) ? "R9 keys preserved" : "R2 keys preserved", mism, 0);
    chk(lasts == 1 && last_at == exp_n, "R4 end flag placement", last_at, exp_n);
    leaf_valid = '0; leaf_last = '0;
    @(negedge clk);
    out_ready = 1'b1;
    repeat (20) begin
      @(negedge clk);
      if (out_valid) lasts++;
    end
    chk(lasts == 1, "R4 nothing after end", lasts, 1);
    chk(leaf_ready == '1, "R8 ready for next batch", int'(leaf_ready), (1 << L) - 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!out_valid, "R7 reset valid", int'(out_valid), 0);
    chk(leaf_ready == '1, "R7 reset ready", int'(leaf_ready), (1 << L) - 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid, "R7 valid after release", int'(out_valid), 0);
    run_batch(0, 0, 0);
    run_batch(1, 0, 0);
    run_batch(0, 30, 30);
    run_batch(2, 10, 40);
    run_batch(3, 20, 20);
    run_batch(4, 0, 50);
    run_batch(0, 60, 10);
    run_batch(1, 40, 70);
    for (int b = 0; b < 4; b++) run_batch(0, int'($urandom % 50), int'($urandom % 50));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule